// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-channel SPI master for an on-chip register bus. Software controls it through a 32-bit register window. The window holds a mode word, a write-one-to-clear event word, an interrupt mask, a command slot, a transmit slot and a receive slot.

Writing the transmit slot while the block is enabled sends one character at once. The character length runs from 4 to 32 bits. Software picks the bit order and a clock prescale value. Data is right-justified in both the transmit and receive slots. A loopback setting sends the outgoing bit stream back into the receiver, so software can test the block without a peripheral.

Chip selects are not part of this block and are driven by separate logic. The block only ever runs as bus master.

Top module: `spim_ctrl`

## Requirements
- R1: The register window uses these byte offsets: mode 0x20, event 0x24, mask 0x28, command 0x2C, transmit 0x30, receive 0x34. In the mode word, bit 30 is loopback, bit 26 selects MSB-first, bit 25 is master select, bit 24 is enable, bits 23:20 are the length code and bits 19:16 are the prescale value. All of these read back, and every other mode bit reads 0. Event and mask use only bits 9 and 8. Command, transmit, reserved offsets and unused bits read 0. Every register resets to 0.
- R2: A write to transmit starts a character only when the enable bit is set. With enable clear, the write produces no SCLK edge and no event.
- R3: The character length is decoded from the length code as follows: code 0 gives 32 bits, codes 3 to 15 give code+1 bits, and codes 1 and 2 give 4 bits.
- R4: Only the low N bits of the transmit word are sent, where N is the character length. With bit 26 set the most significant of those bits goes first; with it clear the least significant goes first. Received bits land in the low N bits of the receive word in the same order, and the bits above them read 0.
- R5: SCLK is low whenever no character is in flight. One SCLK period lasts 4*(P+1) system clocks, where P is the prescale value. The receive-not-empty flag (event bit 9) is first visible N*4*(P+1) clock edges after the edge that accepts the transmit write.
- R6: MOSI carries the first bit before the first rising SCLK edge and changes only on falling edges. MISO is sampled at each rising edge.
- R7: With loopback set, the receiver takes the MOSI stream and ignores MISO, so the receive word equals the masked transmit word.
- R8: Transmit-not-full (event bit 8) is set on the edge that loads a character into the shifter.
- R9: Writing 1 to an event bit clears that bit, and writing 0 leaves it unchanged. A hardware set arriving in the same cycle as a clear takes priority.
- R10: The interrupt output is high exactly when some event bit and its mask bit are both 1.
- R11: A transmit write that arrives while a character is in flight is ignored. The current character finishes unchanged and no second character follows.
- R12: Reading the receive word leaves receive-not-empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a second transmit write landing while the shifter is still busy. A bare register bus never needs to do this, so the bench forces it: it starts an 8-bit character, waits ten cycles, and writes a different transmit word in the middle of the transfer. It then counts every rising SCLK edge over a long quiet window, to show that exactly one character's worth of edges appeared and that the receive data is unchanged. A second hard case is a read of the receive word that must not clear its flag. The bench reaches it by reading receive twice before it examines the event word and the interrupt.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 32;
  localparam int PM_W   = 4;
  localparam int LEN_W  = 4;

  localparam logic [7:0] OFS_MODE = 8'h20;
  localparam logic [7:0] OFS_EVT  = 8'h24;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_CMD  = 8'h2C;
  localparam logic [7:0] OFS_TX   = 8'h30;
  localparam logic [7:0] OFS_RX   = 8'h34;

  localparam int BIT_LOOP  = 30;
  localparam int BIT_MSB   = 26;
  localparam int BIT_MST   = 25;
  localparam int BIT_EN    = 24;
  localparam int LEN_LSB   = 20;
  localparam int PM_LSB    = 16;
  localparam int BIT_RXNE  = 9;
  localparam int BIT_TXNF  = 8;

  typedef struct packed {
    logic             loop;
    logic             msb;
    logic             mst;
    logic             en;
    logic [LEN_W-1:0] len;
    logic [PM_W-1:0]  pm;
  } mode_t;

  // index of the highest data bit for a length code
  function automatic logic [4:0] top_index(input logic [LEN_W-1:0] code);
    logic [4:0] t;
    if (code == '0)        t = 5'd31;
    else if (code < 4'd3)  t = 5'd3;
    else                   t = {1'b0, code};
    return t;
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PM_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);
  localparam int CW = PM_W + 1;

  logic [CW-1:0] cnt_q, cnt_d, last;

  // half period is 2*(pm+1) clocks, so the last count is 2*pm+1
  assign last = {pm, 1'b1};
  assign tick = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DW   = 32,
  parameter int PM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    tx_data,
  input  logic [LEN_W-1:0] len_code,
  input  logic             msb_first,
  input  logic             loopback,
  input  logic [PM_W-1:0]  pm_in,
  input  logic             tick,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic [PM_W-1:0]  pm_o,
  output logic             done,
  output logic [DW-1:0]    rx_word
);
  localparam int IW = $clog2(DW);
  localparam int LW = IW + 1;

  logic            busy_q, busy_d, sclk_q, sclk_d, samp_q, samp_d;
  logic            msb_q, msb_d, loop_q, loop_d;
  logic [DW-1:0]   sh_q, sh_d, shifted;
  logic [LW-1:0]   left_q, left_d;
  logic [IW-1:0]   top_q, top_d, top_new;
  logic [PM_W-1:0] pm_q, pm_d;
  logic            out_bit, rx_in, rise, fall;

  function automatic logic [DW-1:0] len_mask(input logic [IW-1:0] t);
    return {DW{1'b1}} >> (DW - 1 - int'(t));
  endfunction

  assign top_new = IW'(top_index(len_code));
  assign out_bit = msb_q ? sh_q[top_q] : sh_q[0];
  assign rx_in   = loop_q ? out_bit : miso;
  assign rise    = busy_q && tick && !sclk_q;
  assign fall    = busy_q && tick && sclk_q;
  assign shifted = msb_q ? (((sh_q << 1) | DW'(samp_q)) & len_mask(top_q))
                         : ((sh_q >> 1) | (DW'(samp_q) << top_q));
  assign done    = fall && (left_q == LW'(1));

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q && out_bit;
  assign pm_o    = pm_q;
  assign rx_word = shifted;

  always_comb begin
    busy_d = busy_q; sclk_d = sclk_q; samp_d = samp_q;
    msb_d  = msb_q;  loop_d = loop_q; sh_d   = sh_q;
    left_d = left_q; top_d  = top_q;  pm_d   = pm_q;
    if (start) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      sh_d   = tx_data & len_mask(top_new);
      top_d  = top_new;
      left_d = LW'(top_new) + 1'b1;
      msb_d  = msb_first;
      loop_d = loopback;
      pm_d   = pm_in;
    end else begin
      if (rise) begin
        sclk_d = 1'b1;
        samp_d = rx_in;
      end
      if (fall) begin
        sclk_d = 1'b0;
        sh_d   = shifted;
        left_d = left_q - 1'b1;
        if (done) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; samp_q <= 1'b0;
      msb_q  <= 1'b0; loop_q <= 1'b0; sh_q   <= '0;
      left_q <= '0;   top_q  <= '0;   pm_q   <= '0;
    end else begin
      busy_q <= busy_d; sclk_q <= sclk_d; samp_q <= samp_d;
      msb_q  <= msb_d;  loop_q <= loop_d; sh_q   <= sh_d;
      left_q <= left_d; top_q  <= top_d;  pm_q   <= pm_d;
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DW-1:0]     rx_next,
  output logic              start,
  output mode_t             mode,
  output logic              irq,
  output logic [1:0]        ev,
  output logic [1:0]        msk
);
  mode_t          mode_q, mode_d;
  logic [1:0]     ev_q, ev_d, msk_q, msk_d;
  logic [DW-1:0]  rx_q, rx_d;
  logic           wr_mode, wr_evt, wr_mask, wr_tx;

  assign wr_mode = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
  assign wr_evt  = reg_wr && (reg_addr == ADDR_W'(OFS_EVT));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));
  assign wr_tx   = reg_wr && (reg_addr == ADDR_W'(OFS_TX));
  assign start   = wr_tx && mode_q.en && !busy;

  always_comb begin
    mode_d = mode_q;
    msk_d  = msk_q;
    rx_d   = rx_q;
    if (wr_mode) begin
      mode_d.loop = reg_wdata[BIT_LOOP];
      mode_d.msb  = reg_wdata[BIT_MSB];
      mode_d.mst  = reg_wdata[BIT_MST];
      mode_d.en   = reg_wdata[BIT_EN];
      mode_d.len  = reg_wdata[LEN_LSB +: LEN_W];
      mode_d.pm   = reg_wdata[PM_LSB +: PM_W];
    end
    if (wr_mask) msk_d = {reg_wdata[BIT_RXNE], reg_wdata[BIT_TXNF]};
    // clear first, hardware set last so it wins
    ev_d = ev_q;
    if (wr_evt) ev_d = ev_q & ~{reg_wdata[BIT_RXNE], reg_wdata[BIT_TXNF]};
    if (done)  begin ev_d[1] = 1'b1; rx_d = rx_next; end
    if (start) ev_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ev_q <= '0; msk_q <= '0; rx_q <= '0;
    end else begin
      mode_q <= mode_d; ev_q <= ev_d; msk_q <= msk_d; rx_q <= rx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_MODE)) begin
      reg_rdata[BIT_LOOP]            = mode_q.loop;
      reg_rdata[BIT_MSB]             = mode_q.msb;
      reg_rdata[BIT_MST]             = mode_q.mst;
      reg_rdata[BIT_EN]              = mode_q.en;
      reg_rdata[LEN_LSB +: LEN_W]    = mode_q.len;
      reg_rdata[PM_LSB +: PM_W]      = mode_q.pm;
    end else if (reg_addr == ADDR_W'(OFS_EVT)) begin
      reg_rdata[BIT_RXNE] = ev_q[1];
      reg_rdata[BIT_TXNF] = ev_q[0];
    end else if (reg_addr == ADDR_W'(OFS_MASK)) begin
      reg_rdata[BIT_RXNE] = msk_q[1];
      reg_rdata[BIT_TXNF] = msk_q[0];
    end else if (reg_addr == ADDR_W'(OFS_RX)) begin
      reg_rdata = rx_q;
    end
  end

  assign irq  = |(ev_q & msk_q);
  assign mode = mode_q;
  assign ev   = ev_q;
  assign msk  = msk_q;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic            rst_s1, rst_sn;
  logic            start, busy, tick, done;
  logic [DW-1:0]   rx_next;
  logic [PM_W-1:0] pm_run;
  logic [1:0]      ev, msk;
  mode_t           mode;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_s1 <= 1'b0; rst_sn <= 1'b0; end
    else        begin rst_s1 <= 1'b1; rst_sn <= rst_s1; end
  end

  spim_regs #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sn), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .rx_next(rx_next), .start(start), .mode(mode), .irq(irq), .ev(ev), .msk(msk)
  );

  spim_clkdiv #(.PM_W(PM_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .run(busy), .pm(pm_run), .tick(tick)
  );

  spim_shift #(.DW(DW), .PM_W(PM_W)) u_shift (
    .clk(clk), .rst_n(rst_sn), .start(start), .tx_data(reg_wdata),
    .len_code(mode.len), .msb_first(mode.msb), .loopback(mode.loop),
    .pm_in(mode.pm), .tick(tick), .miso(miso), .busy(busy), .sclk(sclk),
    .mosi(mosi), .pm_o(pm_run), .done(done), .rx_word(rx_next)
  );
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DW-1:0]     reg_wdata,
  input logic              irq,
  input logic              sclk,
  input logic              start,
  input logic              busy,
  input logic              tick,
  input logic [1:0]        ev,
  input logic [1:0]        msk
);
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  p_sclk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));

  p_first_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !sclk));

  p_nf_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ev[0]);

  p_ne_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[1] && !(reg_wr && reg_addr == ADDR_W'(8'h24) && reg_wdata[9])) |=> ev[1]);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == 2'b00) |-> !irq);

  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

bind spim_ctrl spim_ctrl_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .irq(irq), .sclk(sclk), .start(start),
  .busy(busy), .tick(tick), .ev(ev), .msk(msk)
);

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sclk, mosi, miso;

  int vectors = 0;
  int fails = 0;
  int rises = 0;

  logic [31:0] slv_word = '0;
  int          slv_n = 8;
  bit          slv_msb = 1'b1;
  int          slv_idx = 0;

  typedef struct { int n; bit msb; logic [31:0] w; } item_t;
  item_t sb_q[$];

  spim_ctrl u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  // peripheral model: bit index advances on every falling SCLK edge
  always_comb begin
    if (slv_idx >= slv_n) miso = 1'b0;
    else if (slv_msb)     miso = slv_word[(slv_n - 1 - slv_idx) & 31];
    else                  miso = slv_word[slv_idx & 31];
  end
  always @(negedge sclk) slv_idx = slv_idx + 1;
  always @(posedge sclk) rises = rises + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int len_of(input logic [3:0] code);
    if (code == 4'd0) return 32;
    if (code < 4'd4)  return 4;
    return int'(code) + 1;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction

  // scoreboard monitor: rebuilds each transmitted character from MOSI
  initial begin
    item_t it;
    logic [31:0] got;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      got = '0;
      for (int i = 0; i < it.n; i++) begin
        @(posedge sclk);
        #1;
        if (it.msb) got = {got[30:0], mosi};
        else        got[i] = mosi;
      end
      chk("R4/R6 mosi stream", got, it.w);
    end
  end

  task automatic xfer(input string tag, input bit lp, input bit msb, input logic [3:0] code,
                      input logic [3:0] pm, input logic [31:0] tx, input logic [31:0] slv);
    int n, j;
    logic [31:0] msk, ev, rx, exp_rx;
    item_t it;
    n = len_of(code);
    msk = mask_of(n);
    exp_rx = lp ? (tx & msk) : (slv & msk);
    wr(8'h20, (32'(lp) << 30) | (32'(msb) << 26) | 32'h0300_0000 |
              (32'(code) << 20) | (32'(pm) << 16));
    wr(8'h24, 32'hFFFF_FFFF);
    slv_word = slv; slv_n = n; slv_msb = msb; slv_idx = 0;
    it.n = n; it.msb = msb; it.w = tx & msk;
    sb_q.push_back(it);
    wr(8'h30, tx);
    rd(8'h24, ev);
    chk({tag, " R8 NF after load"}, ev, 32'h0000_0100);
    j = 0;
    while (ev[9] !== 1'b1 && j < 5000) begin
      @(negedge clk);
      j++;
      rd(8'h24, ev);
    end
    chk({tag, " R5 cycles to NE"}, 32'(j), 32'(n * 4 * (int'(pm) + 1)));
    rd(8'h34, rx);
    chk({tag, " R3/R4/R7 rx word"}, rx, exp_rx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(8'h20, d); chk("R1 mode reset", d, 32'h0);
    rd(8'h24, d); chk("R1 event reset", d, 32'h0);
    rd(8'h28, d); chk("R1 mask reset", d, 32'h0);
    rd(8'h34, d); chk("R1 rx reset", d, 32'h0);
    chk("R1 pins reset", {29'd0, irq, sclk, mosi}, 32'h0);

    // R1 readback and read-as-zero
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R1 mode readback", d, 32'h47FF_0000);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R1 mask readback", d, 32'h0000_0300);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h1234_5678); rd(8'h2C, d); chk("R1 command reads 0", d, 32'h0);
    rd(8'h30, d); chk("R1 transmit reads 0", d, 32'h0);
    rd(8'h00, d); chk("R1 offset 0x00 reads 0", d, 32'h0);
    rd(8'hFC, d); chk("R1 offset 0xFC reads 0", d, 32'h0);

    // R2 disabled transmit write
    wr(8'h20, 32'h0270_0000);
    r0 = rises;
    wr(8'h30, 32'h0000_00FF);
    repeat (60) @(negedge clk);
    chk("R2 no SCLK when disabled", 32'(rises - r0), 32'h0);
    rd(8'h24, d); chk("R2 no event when disabled", d, 32'h0);

    // transfers across lengths, orders and prescales
    xfer("8b msb pm1",   1'b0, 1'b1, 4'd7,  4'd1, 32'h0000_00A5, 32'h0000_003C);
    xfer("16b lsb pm0",  1'b0, 1'b0, 4'd15, 4'd0, 32'h0000_1234, 32'h0000_BEEF);
    xfer("32b msb pm2",  1'b0, 1'b1, 4'd0,  4'd2, 32'hDEAD_BEEF, 32'h1234_5678);
    xfer("4b code3",     1'b0, 1'b1, 4'd3,  4'd0, 32'hFFFF_FFF9, 32'h0000_00F6);
    xfer("4b code1 R3",  1'b0, 1'b1, 4'd1,  4'd0, 32'h0000_000C, 32'h0000_000A);
    xfer("12b lsb pm3",  1'b0, 1'b0, 4'd11, 4'd3, 32'h0000_0ACE, 32'h0000_0531);
    xfer("loop R7",      1'b1, 1'b1, 4'd11, 4'd0, 32'h0000_0C3A, 32'h0000_05A5);

    // R12 receive read keeps NE, R9 write-one-to-clear, R10 interrupt gating
    rd(8'h34, d); rd(8'h34, d);
    rd(8'h24, d); chk("R12 NE kept after rx reads", d, 32'h0000_0300);
    wr(8'h24, 32'h0); rd(8'h24, d); chk("R9 zero write no effect", d, 32'h0000_0300);
    wr(8'h24, 32'h0000_0100); rd(8'h24, d); chk("R9 clear NF only", d, 32'h0000_0200);
    wr(8'h28, 32'h0000_0100); chk("R10 irq low, NF masked-in but clear", 32'(irq), 32'h0);
    wr(8'h28, 32'h0000_0200); chk("R10 irq high on NE", 32'(irq), 32'h1);
    wr(8'h24, 32'h0000_0200); rd(8'h24, d); chk("R9 clear NE", d, 32'h0);
    chk("R10 irq low after clear", 32'(irq), 32'h0);
    wr(8'h28, 32'h0);

    // R11 transmit write during a transfer is ignored
    begin
      item_t it;
      int j;
      wr(8'h20, 32'h0770_0000);
      wr(8'h24, 32'hFFFF_FFFF);
      slv_word = 32'h0000_0081; slv_n = 8; slv_msb = 1'b1; slv_idx = 0;
      it.n = 8; it.msb = 1'b1; it.w = 32'h0000_0066;
      sb_q.push_back(it);
      r0 = rises;
      wr(8'h30, 32'h0000_0066);
      repeat (10) @(negedge clk);
      wr(8'h30, 32'h0000_0099);
      j = 0;
      rd(8'h24, d);
      while (d[9] !== 1'b1 && j < 5000) begin
        @(negedge clk); j++; rd(8'h24, d);
      end
      rd(8'h34, d); chk("R11 rx unchanged by busy write", d, 32'h0000_0081);
      wr(8'h24, 32'hFFFF_FFFF);
      repeat (150) @(negedge clk);
      chk("R11 one character of SCLK", 32'(rises - r0), 32'd8);
      rd(8'h24, d); chk("R11 no second character", d, 32'h0);
    end

    repeat (5) @(negedge clk);
    chk("R4 scoreboard drained", 32'(sb_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule